// File: doc/BRIEF.md
# Shared Shift and Rotate Unit

This is a combinational datapath element for a 32-bit execute stage. It performs either a logical right shift or a right rotate of a data word. The shift amount is the 5-bit value taken from an instruction's immediate field. A single mode bit chooses between the two operations.

Both operations run through the same 64-bit right barrel shifter. In shift mode the upper half of the shifter input is zero. In rotate mode the upper half is a second copy of the data word. In both modes the output is the low 32 bits of the shifted value. In rotate mode, the bits that leave the bottom of the word come back in at the top. For a 5-bit word `[a b c d e]`, a rotate by 2 gives `[d e a b c]`.

The unit has no clock and holds no state. The result settles within the same cycle as the operands.

Top module: `srot_unit`

## Requirements
- R1: With `rot_i` = 0 (shift mode), `result_o` equals `data_i` shifted right by `amt_i` places, and the `amt_i` most significant bits of the result are zero.
- R2: With `rot_i` = 1 (rotate mode) and `amt_i` = k > 0, bits [31:32-k] of `result_o` equal bits [k-1:0] of `data_i`. Bits [31-k:0] of `result_o` equal bits [31:k] of `data_i`.
- R3: When `amt_i` is 0, `result_o` equals `data_i` in both modes.
- R4: In rotate mode, `result_o` has the same number of one bits as `data_i` for every amount. An all-ones word stays all ones.
- R5: In both modes, bits [31-k:0] of `result_o` are identical for the same `data_i` and `amt_i` = k. The two modes differ only in the top k bits.
- R6: Every value of the 5-bit `amt_i` from 0 to 31 is honoured exactly. No amount is reduced, saturated or treated as a special case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 32 | Word to be shifted or rotated |
| amt_i | input | 5 | Right shift or rotate distance, 0 to 31 |
| rot_i | input | 1 | Mode select: 1 = rotate right, 0 = logical shift right |
| result_o | output | 32 | Shifted or rotated word |

## Verification
The unit is combinational. A fault in any barrel stage or in the upper-half feed therefore shows at `result_o` in the same cycle as the stimulus. A broken stage corrupts every result whose amount has that stage's bit set. A wrong feed either leaks data bits into the zero-filled top of a shift, or drops the wrapped bits of a rotate. Sweeping all 32 amounts in both modes, over structured and random words, makes each stage select and each feed path change the output at least once.

// File: rtl/srot_pkg.sv
package srot_pkg;

    localparam int unsigned SR_DATA_W = 32;
    localparam int unsigned SR_AMT_W  = $clog2(SR_DATA_W);

    typedef enum logic {
        SR_SHIFT  = 1'b0,
        SR_ROTATE = 1'b1
    } srot_mode_e;

endpackage

// File: rtl/srot_feed.sv
module srot_feed
    import srot_pkg::*;
#(
    parameter int unsigned W = SR_DATA_W
) (
    input  logic [W-1:0]   word_i,
    input  srot_mode_e     mode_i,
    output logic [2*W-1:0] wide_o
);

    logic [W-1:0] upper_d;

    always_comb begin
        upper_d = '0;
        if (mode_i == SR_ROTATE) begin
            upper_d = word_i;
        end
        wide_o = {upper_d, word_i};
    end

endmodule

// File: rtl/srot_barrel.sv
module srot_barrel #(
    parameter int unsigned WW = 64,
    parameter int unsigned AW = 5
) (
    input  logic [WW-1:0] wide_i,
    input  logic [AW-1:0] amt_i,
    output logic [WW-1:0] wide_o
);

    logic [AW:0][WW-1:0] stage_d;

    assign stage_d[0] = wide_i;

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int unsigned STEP = 2 ** s;
        assign stage_d[s+1] = amt_i[s] ? (stage_d[s] >> STEP) : stage_d[s];
    end

    assign wide_o = stage_d[AW];

endmodule

// File: rtl/srot_unit.sv
module srot_unit
    import srot_pkg::*;
#(
    parameter int unsigned DATA_W = SR_DATA_W,
    localparam int unsigned AMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              rot_i,
    output logic [DATA_W-1:0] result_o
);

    localparam int unsigned WIDE_W = 2 * DATA_W;

    srot_mode_e        mode_d;
    logic [WIDE_W-1:0] fed_d;
    logic [WIDE_W-1:0] shifted_d;

    assign mode_d = srot_mode_e'(rot_i);

    srot_feed #(
        .W (DATA_W)
    ) feed_i (
        .word_i (data_i),
        .mode_i (mode_d),
        .wide_o (fed_d)
    );

    srot_barrel #(
        .WW (WIDE_W),
        .AW (AMT_W)
    ) barrel_i (
        .wide_i (fed_d),
        .amt_i  (amt_i),
        .wide_o (shifted_d)
    );

    assign result_o = shifted_d[DATA_W-1:0];

endmodule

// File: rtl/srot_unit_chk.sv
module srot_unit_chk #(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = 5
) (
    input logic [W-1:0]  data_i,
    input logic [AW-1:0] amt_i,
    input logic          rot_i,
    input logic [W-1:0]  result_o
);

    localparam logic [AW:0] W_L = (AW+1)'(W);

    logic [W-1:0] keep_mask;
    logic [AW:0]  wrap_sh;

    always_comb begin
        keep_mask = {W{1'b1}} >> amt_i;
        wrap_sh   = W_L - {1'b0, amt_i};

        AST_SHIFT_TOP_ZERO: assert (rot_i || ((result_o & ~keep_mask) == '0)); // R1
        AST_ROT_WRAP_BITS: assert (!rot_i || (amt_i == '0) ||
            ((result_o & ~keep_mask) == (data_i << wrap_sh))); // R2
        AST_ZERO_AMT_IDENT: assert ((amt_i != '0) || (result_o == data_i)); // R3
        AST_ROT_POPCOUNT: assert (!rot_i || ($countones(result_o) == $countones(data_i))); // R4
        AST_LOW_PART_MATCH: assert ((result_o & keep_mask) == (data_i >> amt_i)); // R5
    end

endmodule

bind srot_unit srot_unit_chk #(
    .W  (DATA_W),
    .AW (AMT_W)
) chk_i (
    .data_i   (data_i),
    .amt_i    (amt_i),
    .rot_i    (rot_i),
    .result_o (result_o)
);

// File: tb/srot_unit_tb_top.sv
module srot_unit_tb_top;

    logic        clk = 1'b0;
    logic [31:0] data;
    logic [4:0]  amt;
    logic        rot;
    logic [31:0] res;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    srot_unit dut_i (
        .data_i   (data),
        .amt_i    (amt),
        .rot_i    (rot),
        .result_o (res)
    );

    function automatic logic [31:0] ref_model(input logic [31:0] d, input int a, input bit r);
        logic [31:0] v;
        v = d >> a;
        if (r && a != 0) v = v | (d << (32 - a));
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s data=%h amt=%0d rot=%0b actual=%h expected=%h",
                     tag, data, amt, rot, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] d, input int a, input bit r);
        logic [31:0] e;
        @(posedge clk);
        data = d;
        amt  = 5'(a);
        rot  = r;
        @(negedge clk);
        e = ref_model(d, a, r);
        if (a == 0)
            check("R3", res, d);
        else if (r)
            check("R2", res, e);
        else
            check("R1", res, e);
        check("R6", res, e);
        if (r) begin
            total++;
            if ($countones(res) != $countones(d)) begin
                bad++;
                $display("FAIL R4 popcount actual=%0d expected=%0d",
                         $countones(res), $countones(d));
            end
        end
        check("R5", res & (32'hFFFF_FFFF >> a), d >> a);
    endtask

    initial begin
        logic [31:0] pats [8];
        data = '0;
        amt  = '0;
        rot  = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R3", res, 32'h0);
        pats[0] = 32'h0000_0000;
        pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h8000_0001;
        pats[3] = 32'hA5C3_0F96;
        for (int i = 4; i < 8; i++) pats[i] = $urandom;
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 32; a++)
                for (int p = 0; p < 8; p++)
                    apply(pats[p], a, m[0]);
        // R4: all-ones stays all-ones under rotate
        apply(32'hFFFF_FFFF, 17, 1'b1);
        check("R4", res, 32'hFFFF_FFFF);
        // R2: worked wrap example with distinct low bits
        apply(32'h0000_0003, 2, 1'b1);
        check("R2", res, 32'hC000_0000);
        // R1: top bit shifted to bottom by 31
        apply(32'h8000_0000, 31, 1'b0);
        check("R1", res, 32'h0000_0001);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule